// File: doc/BRIEF.md
# Shared-Pin Address Splitter with Region Strobe Decoder

This block sits beside a microcontroller that, when running with external memory, time-shares eight pins between the low byte of the address and the data byte. While the address strobe is high, a transparent latch passes the shared pins to a dedicated low-address bus. When the strobe falls, the latch freezes that byte. The external low address then stays steady while the same pins go on to carry data.

In parallel, a one-of-eight decoder turns the upper address bits, the read/write line and the bus clock phase into active-low select strobes. The decoder is gated so that it only acts in the lower half of the address map and only while the bus clock phase is high. The read/write line is the least significant select bit, so a read and a write to the same region produce two different strobes. Memory and peripheral chips can then take a read enable or a write enable directly from a select line.

Both paths are combinational or level-sensitive; there is no clock or reset inside the block.

Top module: `bus_addr_split`

## Requirements
- R1: While `astb_i` is 1, `addr_lo_o` equals `ad_bus_i` and follows every change on it.
- R2: While `astb_i` is 0, `addr_lo_o` keeps the value present when `astb_i` fell, whatever `ad_bus_i` does.
- R3: While `eclk_i` is 0, all eight bits of `sel_n_o` are 1.
- R4: While `addr_hi_i[7]` (address bit 15) is 1, all eight bits of `sel_n_o` are 1.
- R5: While `eclk_i` is 1 and `addr_hi_i[7]` is 0, exactly one bit of `sel_n_o` is 0. Its index is {`addr_hi_i[6]`, `addr_hi_i[5]`, `rd_wrn_i`}, with bit 14 as the MSB and `rd_wrn_i` = 1 meaning read.
- R6: Reads and writes to one region get distinct strobes. Bit 14 = 0 and bit 13 = 1 gives bit 2 for a write and bit 3 for a read. Bit 14 = 1 and bit 13 = 0 gives bit 4 for a write and bit 5 for a read.
- R7: `addr_hi_i[4:0]`, `ad_bus_i` and `astb_i` have no effect on `sel_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ad_bus_i | input | 8 | Shared pins: low address byte during the strobe, data afterwards |
| addr_hi_i | input | 8 | Address bits 15..8 |
| astb_i | input | 1 | Address strobe; high makes the latch transparent |
| eclk_i | input | 1 | Bus clock phase; high enables the decoder |
| rd_wrn_i | input | 1 | 1 = read, 0 = write |
| addr_lo_o | output | 8 | Latched low address byte |
| sel_n_o | output | 8 | Active-low region/direction strobes |

## Verification
The decoder is tried with every combination of the region bits and the read/write line while enabled. This separates a swapped or wrongly ordered select bit, because each of the eight outputs must come out alone. The same codes are then applied with the clock phase low and with address bit 15 set, which shows whether each enable term gates on its own. The latch is driven with changing bytes while transparent and again after the strobe falls. That tells a true hold apart from a pass-through or an edge-triggered capture. Toggling the unused address bits and the shared pins against a fixed select confirms that they do not reach the strobes.

// File: rtl/bus_addr_split.sv
module bus_addr_split #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] ad_bus_i,
  input  logic [7:0]        addr_hi_i,
  input  logic              astb_i,
  input  logic              eclk_i,
  input  logic              rd_wrn_i,
  output logic [BYTE_W-1:0] addr_lo_o,
  output logic [7:0]        sel_n_o
);

  localparam int NSEL = 8;

  logic [BYTE_W-1:0] lo_q;
  logic              dec_en;
  logic [2:0]        dec_idx;

  always_latch begin
    if (astb_i) lo_q <= ad_bus_i;
  end

  assign addr_lo_o = lo_q;

  assign dec_en  = eclk_i & ~addr_hi_i[7];
  assign dec_idx = {addr_hi_i[6], addr_hi_i[5], rd_wrn_i};

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    assign sel_n_o[k] = ~(dec_en && (dec_idx == 3'(k)));
  end

  // Latch is transparent right up to the falling strobe.
  assert_latch_capture_R1: assert property (@(negedge astb_i)
    addr_lo_o == ad_bus_i);

  // Just before the phase rises it was low, so no strobe may be asserted.
  assert_idle_when_phase_low_R3: assert property (@(posedge eclk_i)
    sel_n_o == '1);

  assert_idle_upper_half_R4: assert property (@(negedge eclk_i)
    addr_hi_i[7] |-> sel_n_o == '1);

  assert_single_strobe_R5: assert property (@(negedge eclk_i)
    !addr_hi_i[7] |-> ($countones(~sel_n_o) == 1));

  assert_strobe_index_R6: assert property (@(negedge eclk_i)
    !addr_hi_i[7] |-> (sel_n_o[{addr_hi_i[6], addr_hi_i[5], rd_wrn_i}] == 1'b0));

endmodule

// File: tb/bus_addr_split_bench.sv
module bus_addr_split_bench;

  logic       clk = 1'b0;
  logic [7:0] ad = 8'h00;
  logic [7:0] ahi = 8'h00;
  logic       as = 1'b0;
  logic       e = 1'b0;
  logic       rw = 1'b1;
  logic [7:0] alo;
  logic [7:0] seln;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_addr_split u_bus_addr_split (
    .ad_bus_i(ad), .addr_hi_i(ahi), .astb_i(as), .eclk_i(e),
    .rd_wrn_i(rw), .addr_lo_o(alo), .sel_n_o(seln)
  );

  // {a15, a14, a13, rw, e, expected sel_n}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {5'b0_0_0_0_1, 8'b1111_1110},
    {5'b0_0_0_1_1, 8'b1111_1101},
    {5'b0_0_1_0_1, 8'b1111_1011},
    {5'b0_0_1_1_1, 8'b1111_0111},
    {5'b0_1_0_0_1, 8'b1110_1111},
    {5'b0_1_0_1_1, 8'b1101_1111},
    {5'b0_1_1_0_1, 8'b1011_1111},
    {5'b0_1_1_1_1, 8'b0111_1111},
    {5'b0_0_1_0_0, 8'b1111_1111},
    {5'b0_1_0_1_0, 8'b1111_1111},
    {5'b0_1_1_1_0, 8'b1111_1111},
    {5'b1_0_1_0_1, 8'b1111_1111},
    {5'b1_0_1_1_1, 8'b1111_1111},
    {5'b1_1_0_0_1, 8'b1111_1111},
    {5'b1_1_1_1_1, 8'b1111_1111},
    {5'b1_0_0_0_0, 8'b1111_1111}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    check8("R3 initial idle", seln, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ahi = {VEC[i][12], VEC[i][11], VEC[i][10], 5'b01010};
      rw  = VEC[i][9];
      e   = VEC[i][8];
      @(posedge clk); #1;
      if (VEC[i][12]) check8("R4 upper half idle", seln, VEC[i][7:0]);
      else if (!VEC[i][8]) check8("R3 phase low idle", seln, VEC[i][7:0]);
      else check8("R5 R6 decode", seln, VEC[i][7:0]);
      @(negedge clk);
      e = 1'b0;
    end

    // R1 transparency
    @(negedge clk); as = 1'b1; ad = 8'hA5;
    @(posedge clk); #1; check8("R1 follow", alo, 8'hA5);
    @(negedge clk); ad = 8'h3C;
    @(posedge clk); #1; check8("R1 follow change", alo, 8'h3C);

    // R2 hold
    @(negedge clk); as = 1'b0;
    @(negedge clk); ad = 8'hFF;
    @(posedge clk); #1; check8("R2 hold vs FF", alo, 8'h3C);
    @(negedge clk); ad = 8'h00; e = 1'b1; ahi = 8'h20; rw = 1'b0;
    @(posedge clk); #1; check8("R2 hold during data phase", alo, 8'h3C);
    check8("R6 write region 2", seln, 8'b1111_1011);

    // R7 unused inputs do not reach strobes
    @(negedge clk); ahi = 8'h3F; ad = 8'h5A; as = 1'b1;
    @(posedge clk); #1; check8("R7 low bits/bus ignored", seln, 8'b1111_1011);
    check8("R1 new capture", alo, 8'h5A);
    @(negedge clk); as = 1'b0; ahi = 8'h40; rw = 1'b1; ad = 8'h11;
    @(posedge clk); #1; check8("R6 read region 4", seln, 8'b1101_1111);
    check8("R2 hold second byte", alo, 8'h5A);
    @(negedge clk); e = 1'b0;
    @(posedge clk); #1; check8("R3 phase drop", seln, 8'hFF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule